// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block takes twenty-four asynchronous interrupt pins and turns each one into a request inside the clock domain. Every pin passes through a two-flop synchroniser. It is then compared against a trigger kind chosen per pin: low level, high level, falling edge, rising edge or either edge. Each pin has a three-bit selector, held in one of three trigger-control words on a simple register bus.

The four lowest pins are treated as primary sources. Their detected event goes straight out on a dedicated request line, with no latching and no masking. Pins 4 to 23 set sticky bits in a pending register, which software clears by writing ones. A mask register gates those bits before they are reduced onto two parent request lines. The lower parent covers pins 4 to 7. The upper parent covers pins 8 to 23. A first-level interrupt controller treats each parent as one cascaded source, and software then reads the pending and mask registers to find the pin that fired.

Top module: `xtrig_unit`

## Requirements
- R1: After reset every trigger field is 000 and the pending register reads 0. The mask register reads 0x00FFFFF0, meaning pins 4 to 23 are masked and bits 0 to 3 read 0. All request outputs are low. The synchroniser and previous-value flops reset to 1, so a pin held high through reset raises no event.
- R2: Register addresses are: 0 for pins 0 to 7, 1 for pins 8 to 15, 2 for pins 16 to 23, 3 for the mask and 4 for pending. Pin n uses bits [4*(n%8)+2 : 4*(n%8)] of the word at address n/8. Bit 3 of every field reads back as 0.
- R3: Trigger code 000 is low level and 001 is high level. The event is present in every cycle that the synchronised pin sits at that level.
- R4: Trigger codes 01x select falling edge, 10x rising edge and 11x both edges. Each qualifying transition raises exactly one event, and a transition of the other polarity raises none.
- R5: Suppose a pin changes before clock edge k. The direct request follows at edge k+2, and a pending bit together with its parent request follows at edge k+3. An edge event on a direct line lasts exactly one cycle.
- R6: Writing a 1 to a bit at address 4 clears that pending bit. Writing a 0 leaves the bit unchanged.
- R7: If a new event and a write-1 clear hit the same pending bit in the same cycle, the bit stays set. A held level therefore re-asserts its bit immediately after a clear.
- R8: A set mask bit keeps that pin's pending bit off both parent lines, but the pending bit is still recorded.
- R9: parent_lo_req is the OR of unmasked pending bits 4 to 7. parent_hi_req is the OR of unmasked pending bits 8 to 23.
- R10: Pins 0 to 3 drive direct_req[3:0] from their detected event. They have no pending bit, and the mask does not affect them.
- R11: A write to any address from 5 to 7 changes nothing, and a read from those addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 24 | Asynchronous interrupt pins |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| direct_req | output | 4 | Request lines for pins 0 to 3 |
| parent_lo_req | output | 1 | Cascaded request for pins 4 to 7 |
| parent_hi_req | output | 1 | Cascaded request for pins 8 to 23 |

## Verification
The collision that matters is a write-1 clear from software landing in the same cycle as a fresh trigger event on the same pending bit. The bench provokes it in two ways. First, it holds a high-level pin active while clearing its bit. Second, it times a rising edge so that its pending update coincides exactly with the clear write, which lands three edges after the pin change. The bit must read back as set in both cases. A second clear with no event must then leave the bit at 0, which shows that the clear itself works.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    localparam int CFG_W   = 3;
    localparam int FIELD_W = 4;

    localparam logic [CFG_W-1:0] TRIG_LOW  = 3'b000;
    localparam logic [CFG_W-1:0] TRIG_HIGH = 3'b001;

    // Upper two selector bits choose the family, bit 0 only matters for levels.
    function automatic logic trig_fire(input logic [CFG_W-1:0] sel,
                                       input logic cur,
                                       input logic prv);
        logic hit;
        case (sel[2:1])
            2'b00:   hit = sel[0] ? cur : ~cur;
            2'b01:   hit = prv & ~cur;
            2'b10:   hit = ~prv & cur;
            default: hit = prv ^ cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    // Reset high: an idle-high pin is quiet under the reset trigger code.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
    import xtrig_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             cur_i,
    output logic             evt_o
);

    typedef struct packed {
        logic prv;
        logic evt;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.prv = cur_i;
        st_d.evt = trig_fire(cfg_i, cur_i, st_q.prv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prv: 1'b1, evt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

    assert_level_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == TRIG_HIGH && cur_i) |=> evt_o);

    assert_fall_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[2:1] == 2'b01 && st_q.prv && !cur_i) |=> evt_o);

endmodule

// File: rtl/xtrig_regs.sv
module xtrig_regs
    import xtrig_pkg::*;
#(
    parameter int NUM_PINS   = 24,
    parameter int NUM_DIRECT = 4,
    parameter int GROUP_PINS = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_en,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]             set_vec,
    output logic [NUM_PINS-1:0][CFG_W-1:0]  cfg_o,
    output logic [NUM_PINS-1:0]             mask_o,
    output logic [NUM_PINS-1:0]             pend_o
);

    localparam int NUM_GROUPS = (NUM_PINS + GROUP_PINS - 1) / GROUP_PINS;
    localparam int ADDR_MASK  = NUM_GROUPS;
    localparam int ADDR_PEND  = NUM_GROUPS + 1;
    localparam logic [NUM_PINS-1:0] LATCH_BITS = {NUM_PINS{1'b1}} << NUM_DIRECT;

    typedef struct packed {
        logic [NUM_PINS-1:0][CFG_W-1:0] cfg;
        logic [NUM_PINS-1:0]            mask;
        logic [NUM_PINS-1:0]            pend;
    } regs_t;

    regs_t rg_d, rg_q;
    logic                wr_hit;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] set_kept;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr_hit       = bus_en & bus_we;
    assign set_kept     = set_vec & LATCH_BITS;

    always_comb begin
        clr_vec = '0;
        if (wr_hit && int'(bus_addr) == ADDR_PEND) begin
            clr_vec = bus_wdata[NUM_PINS-1:0];
        end
    end

    always_comb begin
        rg_d = rg_q;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_hit && int'(bus_addr) == p / GROUP_PINS) begin
                rg_d.cfg[p] = bus_wdata[(p % GROUP_PINS) * FIELD_W +: CFG_W];
            end
        end
        if (wr_hit && int'(bus_addr) == ADDR_MASK) begin
            rg_d.mask = bus_wdata[NUM_PINS-1:0] & LATCH_BITS;
        end
        // New events are ORed after the clear, so they win a collision.
        rg_d.pend = ((rg_q.pend & ~clr_vec) | set_vec) & LATCH_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{cfg: '0, mask: LATCH_BITS, pend: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (int'(bus_addr) == p / GROUP_PINS) begin
                bus_rdata[(p % GROUP_PINS) * FIELD_W +: CFG_W] = rg_q.cfg[p];
            end
        end
        if (int'(bus_addr) == ADDR_MASK) begin
            bus_rdata[NUM_PINS-1:0] = rg_q.mask;
        end
        if (int'(bus_addr) == ADDR_PEND) begin
            bus_rdata[NUM_PINS-1:0] = rg_q.pend;
        end
    end

    assign cfg_o  = rg_q.cfg;
    assign mask_o = rg_q.mask;
    assign pend_o = rg_q.pend;

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((rg_q.pend & $past(clr_vec & ~set_vec)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_kept) |=> ((rg_q.pend & $past(set_kept)) == $past(set_kept)));

endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
    import xtrig_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int NUM_DIRECT  = 4,
    parameter int LO_SPLIT    = 8,
    parameter int GROUP_PINS  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_DIRECT-1:0] direct_req,
    output logic                  parent_lo_req,
    output logic                  parent_hi_req
);

    logic [NUM_PINS-1:0]            pin_sync;
    logic [NUM_PINS-1:0]            evt;
    logic [NUM_PINS-1:0][CFG_W-1:0] cfg;
    logic [NUM_PINS-1:0]            mask;
    logic [NUM_PINS-1:0]            pend;
    logic [NUM_PINS-1:0]            live;

    xtrig_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        xtrig_detect u_det (
            .clk  (clk),
            .rst_n(rst_n),
            .cfg_i(cfg[p]),
            .cur_i(pin_sync[p]),
            .evt_o(evt[p])
        );
    end

    xtrig_regs #(
        .NUM_PINS  (NUM_PINS),
        .NUM_DIRECT(NUM_DIRECT),
        .GROUP_PINS(GROUP_PINS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .set_vec  (evt),
        .cfg_o    (cfg),
        .mask_o   (mask),
        .pend_o   (pend)
    );

    assign live          = pend & ~mask;
    assign direct_req    = evt[NUM_DIRECT-1:0];
    assign parent_lo_req = |live[LO_SPLIT-1:NUM_DIRECT];
    assign parent_hi_req = |live[NUM_PINS-1:LO_SPLIT];

    assert_mask_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask[LO_SPLIT-1:NUM_DIRECT]) |-> !parent_lo_req);

    assert_mask_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask[NUM_PINS-1:LO_SPLIT]) |-> !parent_hi_req);

endmodule

// File: tb/xtrig_unit_test.sv
`timescale 1ns/100ps
module xtrig_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin_in = '1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  direct_req;
    logic        parent_lo_req;
    logic        parent_hi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] MASK_ALL = 32'h00FF_FFF0;

    always #2.5 clk = ~clk;

    xtrig_unit uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .direct_req(direct_req), .parent_lo_req(parent_lo_req),
        .parent_hi_req(parent_hi_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pin_in[p] = v;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        idle(4);
        check("R1 direct", 32'(direct_req), 0);
        check("R1 parents", {30'd0, parent_hi_req, parent_lo_req}, 0);
        for (int a = 0; a < 3; a++) begin
            bus_read(3'(a), d);
            check("R1 ctrl", d, 0);
        end
        bus_read(3, d); check("R1 mask", d, MASK_ALL);
        bus_read(4, d); check("R1 pend", d, 0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        bus_write(1, 32'hFFFF_FFFF);
        bus_read(1, d); check("R2 field bit3 zero", d, 32'h7777_7777);
        bus_read(0, d); check("R2 group0 untouched", d, 0);
        bus_read(2, d); check("R2 group2 untouched", d, 0);
        bus_write(1, 0);
        bus_write(2, 32'h0000_0040);
        bus_read(2, d); check("R2 pin17 field", d, 32'h40);
        bus_write(2, 0);
        bus_write(6, 32'hFFFF_FFFF);
        bus_write(5, 32'hFFFF_FFFF);
        bus_read(6, d); check("R11 unmapped read", d, 0);
        bus_read(0, d); check("R11 ctrl0 intact", d, 0);
        bus_read(3, d); check("R11 mask intact", d, MASK_ALL);
        bus_read(4, d); check("R11 pend intact", d, 0);
    endtask

    task automatic t_direct;
        logic [31:0] d;
        bus_write(0, 32'h0000_0400);
        set_pin(2, 1'b0);
        idle(6);
        check("R4 falling ignored in rise mode", 32'(direct_req), 0);
        @(negedge clk); pin_in[2] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R5 direct before k+2", 32'(direct_req[2]), 0);
        @(posedge clk); #1;
        check("R5 direct at k+2", 32'(direct_req[2]), 1);
        @(posedge clk); #1;
        check("R5 edge pulse one cycle", 32'(direct_req[2]), 0);
        bus_read(4, d); check("R10 no pending for direct pin", d, 0);
        bus_write(0, 0);
        set_pin(1, 1'b0);
        idle(5);
        check("R10 level direct", 32'(direct_req), 32'h2);
        bus_write(3, 32'h0000_000F);
        bus_read(3, d); check("R10 mask low bits read zero", d, 0);
        check("R10 mask no effect on direct", 32'(direct_req), 32'h2);
        bus_read(4, d); check("R10 pend low bits zero", d, 0);
        set_pin(1, 1'b1);
        bus_write(3, MASK_ALL);
        idle(5);
        check("R10 direct released", 32'(direct_req), 0);
    endtask

    task automatic t_level_high;
        logic [31:0] d;
        bus_write(2, 32'h0000_0001);
        idle(5);
        bus_read(4, d); check("R3 high level pending", d, 32'h0001_0000);
        bus_write(4, 32'h0001_0000);
        bus_read(4, d); check("R7 level re-asserts after clear", d, 32'h0001_0000);
        bus_write(4, 0);
        bus_read(4, d); check("R6 write zero no effect", d, 32'h0001_0000);
        set_pin(16, 1'b0);
        idle(5);
        bus_write(4, 32'h0001_0000);
        bus_read(4, d); check("R6 clear sticks when idle", d, 0);
        set_pin(16, 1'b1);
        bus_write(2, 0);
        idle(5);
        bus_write(4, 32'h00FF_FFFF);
        bus_read(4, d); check("R6 clean after restore", d, 0);
    endtask

    task automatic t_low_mask;
        logic [31:0] d;
        set_pin(6, 1'b0);
        idle(6);
        check("R8 masked lo parent quiet", 32'(parent_lo_req), 0);
        bus_read(4, d); check("R8 masked pin still pending", d, 32'h40);
        bus_write(3, MASK_ALL & ~32'h40);
        #1;
        check("R9 lo parent on", 32'(parent_lo_req), 1);
        check("R9 hi parent off", 32'(parent_hi_req), 0);
        set_pin(6, 1'b1);
        idle(5);
        bus_write(4, 32'h40);
        #1;
        check("R9 lo parent drops", 32'(parent_lo_req), 0);
        bus_write(3, MASK_ALL);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        bus_write(1, 32'h0003_0000);
        set_pin(12, 1'b0);
        idle(6);
        bus_read(4, d); check("R4 falling sets pending", d, 32'h1000);
        bus_write(4, 32'h1000);
        idle(5);
        bus_read(4, d); check("R4 single event per edge", d, 0);
        set_pin(12, 1'b1);
        idle(6);
        bus_read(4, d); check("R4 rising ignored in fall mode", d, 0);
        bus_write(1, 0);
    endtask

    task automatic t_both;
        logic [31:0] d;
        bus_write(2, 32'h0006_0000);
        bus_write(3, MASK_ALL & ~32'h0010_0000);
        set_pin(20, 1'b0);
        idle(6);
        bus_read(4, d); check("R4 both: falling", d, 32'h0010_0000);
        check("R9 hi parent on", 32'(parent_hi_req), 1);
        bus_write(4, 32'h0010_0000);
        #1;
        check("R9 hi parent off after clear", 32'(parent_hi_req), 0);
        set_pin(20, 1'b1);
        idle(6);
        bus_read(4, d); check("R4 both: rising", d, 32'h0010_0000);
        bus_write(4, 32'h0010_0000);
        idle(4);
        bus_read(4, d); check("R4 both: no repeat", d, 0);
        bus_write(3, MASK_ALL);
        bus_write(2, 0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        bus_write(1, 32'h0000_0400);
        set_pin(10, 1'b0);
        idle(6);
        bus_write(4, 32'h0400);
        set_pin(10, 1'b1);
        idle(6);
        set_pin(10, 1'b0);
        idle(6);
        bus_read(4, d); check("R7 setup pending", d, 32'h0400);
        @(negedge clk); pin_in[10] = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk);
        bus_write(4, 32'h0400);
        bus_read(4, d); check("R7 set wins same-cycle clear", d, 32'h0400);
        bus_write(4, 32'h0400);
        bus_read(4, d); check("R6 later clear works", d, 0);
        bus_write(1, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_map();
        t_direct();
        t_level_high();
        t_low_mask();
        t_fall();
        t_both();
        t_set_wins();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule